// File: doc/BRIEF.md
# Access-Code Lock Controller

This block guards a serial memory against unwanted program and erase operations. It sits behind a serial shifter that has already assembled whole bytes. For each byte the shifter gives a byte-valid strobe, and on the first byte of a frame it also gives a start-of-frame strobe. When the frame closes, the shifter sends a separate frame-end strobe. The block reads the first byte of every frame as an opcode. It handles only the commands that concern protection, and it ignores every other opcode.

The block has three modes. It is unprotected when no access code is stored, locked when it refuses writes, and unlocked when the correct code has been given. The stored code is one to eight bytes long and sits in plain registers. A code change needs the old code, the new code, and the new code again as a check. A single-use override lets exactly one following instruction bypass protection. The memory command executor reads the write-permit flag and the override flag directly.

Top module: `code_lock`

## Requirements
- R1: After reset the mode is unprotected (`mode` = 0), `wr_permit` is 1, `ovr_act` is 0 and the stored code length is 0.
- R2: A frame whose opcode byte is 8'h88 sets the mode to locked (`mode` = 1) on the clock after that byte, and `wr_permit` drops to 0.
- R3: Opcode 8'hC5 followed by exactly the stored code bytes sets the mode to unlocked (`mode` = 2) on the clock after the last code byte. Further bytes in that frame are ignored. With a stored length of 0, the opcode alone unlocks a locked device.
- R4: An unlock with any wrong code byte, or one whose frame ends before all code bytes arrive, leaves the device locked.
- R5: Opcode 8'hD0+L with L from 1 to 8 is followed by the old code (only when a code is stored), then L new bytes, then the same L bytes again. On full agreement the new code of length L is stored and the mode becomes unlocked after the final byte.
- R6: If the old code is wrong, or the confirming copy differs from the new code, the stored code and the mode stay unchanged.
- R7: Opcode 8'hD0 with a correct old code (or with no stored code) clears the stored length to 0 and makes the device unprotected.
- R8: A modify opcode with L greater than 8 makes the rest of its frame ignored, and the mode and code stay unchanged.
- R9: Opcode 8'h83 raises `ovr_act` on the next clock. The flag survives the end of its own frame, stays through the whole following frame, and drops on that frame's frame-end strobe. Outside that point it only changes after an opcode byte.
- R10: Bytes without `byte_vld`, bytes after a command has completed, bytes outside any command, and unknown opcodes have no effect.
- R11: `mode` is 0 unprotected, 1 locked, 2 unlocked and never 3. `wr_permit` is 1 exactly when the mode is not locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sof | input | 1 | Marks the valid byte that opens a frame |
| byte_vld | input | 1 | A byte is present on `byte_in` |
| byte_in | input | 8 | Received byte |
| frm_end | input | 1 | Frame closed |
| mode | output | 2 | Protection mode |
| wr_permit | output | 1 | Program and erase allowed by mode |
| ovr_act | output | 1 | One-instruction protection override |

## Verification
The assertions check on every cycle that the lock opcode takes effect at once and that a locked device never leaves that mode without a byte. They also check that an illegal length leaves the mode alone, that the override rises only after its opcode and falls only at a frame end, and that the mode encoding stays legal. Several properties can only be shown by the bench's scenarios, because they depend on stored contents over whole sequences of frames. These are: whether a code was truly kept or replaced after a failed modify, whether the confirming copy is compared byte by byte, whether a cleared code lets a bare unlock opcode through, and the eight-byte boundary.

// File: rtl/code_lock.sv
module code_lock #(
  parameter int MAX_LEN = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sof,
  input  logic       byte_vld,
  input  logic [7:0] byte_in,
  input  logic       frm_end,
  output logic [1:0] mode,
  output logic       wr_permit,
  output logic       ovr_act
);
  localparam int IW = $clog2(MAX_LEN + 1);
  localparam int AW = $clog2(MAX_LEN);
  localparam logic [7:0] OP_LOCK = 8'h88;
  localparam logic [7:0] OP_UNLK = 8'hC5;
  localparam logic [7:0] OP_OVR  = 8'h83;
  localparam logic [3:0] OP_MOD  = 4'hD;
  localparam logic [1:0] MD_OPEN = 2'd0, MD_LOCK = 2'd1, MD_UNLK = 2'd2;

  typedef enum logic [2:0] {P_IDLE, P_SKIP, P_DONE, P_UNLK, P_OLD, P_NEW, P_CFM} ph_t;

  ph_t           ph;
  logic [IW-1:0] idx, len, nlen, tgt;
  logic [7:0]    code [MAX_LEN];
  logic [7:0]    nbuf [MAX_LEN];
  logic [7:0]    ref_b;
  logic          bad, bad_n, last, ovr, ovr_arm;
  logic [AW-1:0] ia;

  assign ia        = idx[AW-1:0];
  assign tgt       = (ph == P_NEW || ph == P_CFM) ? nlen : len;
  assign last      = (idx == tgt - 1'b1);
  assign ref_b     = (ph == P_CFM) ? nbuf[ia] : code[ia];
  assign bad_n     = bad | (byte_in != ref_b);
  assign wr_permit = (mode != MD_LOCK);
  assign ovr_act   = ovr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= P_IDLE;
      mode    <= MD_OPEN;
      idx     <= '0;
      len     <= '0;
      nlen    <= '0;
      bad     <= 1'b0;
      ovr     <= 1'b0;
      ovr_arm <= 1'b0;
      for (int i = 0; i < MAX_LEN; i++) begin
        code[i] <= '0;
        nbuf[i] <= '0;
      end
    end else begin
      if (byte_vld && sof) begin
        idx <= '0;
        bad <= 1'b0;
        if (ovr) ovr_arm <= 1'b1;
        if (byte_in == OP_LOCK) begin
          mode <= MD_LOCK;
          ph   <= P_DONE;
        end else if (byte_in == OP_OVR) begin
          ovr     <= 1'b1;
          ovr_arm <= 1'b0;
          ph      <= P_DONE;
        end else if (byte_in == OP_UNLK) begin
          if (len == '0) begin
            if (mode == MD_LOCK) mode <= MD_UNLK;
            ph <= P_DONE;
          end else begin
            ph <= P_UNLK;
          end
        end else if (byte_in[7:4] == OP_MOD) begin
          if (int'(byte_in[3:0]) > MAX_LEN) begin
            ph <= P_SKIP;
          end else begin
            nlen <= IW'(byte_in[3:0]);
            if (len != '0) ph <= P_OLD;
            else if (byte_in[3:0] != 4'd0) ph <= P_NEW;
            else begin
              mode <= MD_OPEN;
              ph   <= P_DONE;
            end
          end
        end else begin
          ph <= P_DONE;
        end
      end else if (byte_vld) begin
        case (ph)
          P_UNLK: begin
            if (last) begin
              if (!bad_n) mode <= MD_UNLK;
              ph <= P_DONE;
            end else begin
              idx <= idx + 1'b1;
              bad <= bad_n;
            end
          end
          P_OLD: begin
            if (last) begin
              idx <= '0;
              bad <= 1'b0;
              if (bad_n) ph <= P_SKIP;
              else if (nlen == '0) begin
                len  <= '0;
                mode <= MD_OPEN;
                ph   <= P_DONE;
              end else ph <= P_NEW;
            end else begin
              idx <= idx + 1'b1;
              bad <= bad_n;
            end
          end
          P_NEW: begin
            nbuf[ia] <= byte_in;
            if (last) begin
              idx <= '0;
              ph  <= P_CFM;
            end else idx <= idx + 1'b1;
          end
          P_CFM: begin
            if (last) begin
              if (!bad_n) begin
                code <= nbuf;
                len  <= nlen;
                mode <= MD_UNLK;
              end
              ph <= P_DONE;
            end else begin
              idx <= idx + 1'b1;
              bad <= bad_n;
            end
          end
          default: ;
        endcase
      end
      if (frm_end) begin
        ph <= P_IDLE;
        if (ovr_arm) begin
          ovr     <= 1'b0;
          ovr_arm <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/code_lock_chk.sv
module code_lock_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sof,
  input logic       byte_vld,
  input logic [7:0] byte_in,
  input logic       frm_end,
  input logic [1:0] mode,
  input logic       wr_permit,
  input logic       ovr_act
);
  AST_LOCK_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld && sof && byte_in == 8'h88 |=> mode == 2'd1 && !wr_permit); // R2
  AST_LOCK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'd1 && !byte_vld |=> mode == 2'd1); // R4
  AST_LEN_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld && sof && byte_in[7:4] == 4'hD && byte_in[3:0] > 4'd8 |=> $stable(mode)); // R8
  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld && sof && byte_in == 8'h83 |=> ovr_act); // R9
  AST_OVR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_act && !frm_end |=> ovr_act); // R9
  AST_OVR_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !ovr_act && !(byte_vld && sof) |=> !ovr_act); // R9
  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'd3); // R11
endmodule

bind code_lock code_lock_chk u_chk (.*);

// File: tb/test_code_lock.sv
module test_code_lock;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sof = 1'b0, byte_vld = 1'b0, frm_end = 1'b0;
  logic [7:0] byte_in = 8'h00;
  logic [1:0] mode;
  logic       wr_permit, ovr_act;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  code_lock i_code_lock (.clk, .rst_n, .sof, .byte_vld, .byte_in, .frm_end,
                         .mode, .wr_permit, .ovr_act);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_mode(input string tag, input int exp);
    chk(mode == exp, tag, mode, exp);
    chk(wr_permit == (exp != 1), {tag, " permit"}, wr_permit, exp != 1);
  endtask

  task automatic put(input logic [7:0] b, input bit s, input bit v = 1'b1);
    byte_in = b; sof = s; byte_vld = v;
    @(negedge clk);
    sof = 1'b0; byte_vld = 1'b0;
  endtask

  task automatic fend();
    frm_end = 1'b1;
    @(negedge clk);
    frm_end = 1'b0;
    @(negedge clk);
  endtask

  task automatic frame(input logic [7:0] op, input logic [7:0] d [], input bit close = 1'b1);
    put(op, 1'b1);
    foreach (d[i]) put(d[i], 1'b0);
    if (close) fend();
  endtask

  task automatic t_reset();
    chk_mode("R1 reset mode", 0);
    chk(ovr_act == 0, "R1 reset ovr", ovr_act, 0);
  endtask

  task automatic t_ignore();
    put(8'h88, 1'b1, 1'b0);
    chk_mode("R10 invalid byte", 0);
    put(8'h88, 1'b0);
    chk_mode("R10 byte outside frame", 0);
    frame(8'h42, '{8'h88});
    chk_mode("R10 unknown opcode", 0);
  endtask

  task automatic t_set_code();
    frame(8'hD3, '{8'hAA, 8'hBB, 8'hCC, 8'hAA, 8'hBB}, 1'b0);
    chk_mode("R5 not before last byte", 0);
    put(8'hCC, 1'b0);
    chk_mode("R5 code set", 2);
    fend();
  endtask

  task automatic t_lock();
    frame(8'h88, '{});
    chk_mode("R2 lock", 1);
  endtask

  task automatic t_unlock_bad();
    frame(8'hC5, '{8'hAA, 8'hBB, 8'hCD});
    chk_mode("R4 wrong code", 1);
    frame(8'hC5, '{8'hAA, 8'hBB});
    chk_mode("R4 short frame", 1);
    frame(8'hC5, '{8'hCC});
    chk_mode("R4 no carry over", 1);
  endtask

  task automatic t_unlock_ok(input logic [7:0] d [], input string tag);
    frame(8'hC5, d, 1'b0);
    chk_mode(tag, 2);
    put(8'h88, 1'b0);
    chk_mode("R3 extra byte ignored", 2);
    fend();
  endtask

  task automatic t_mod_bad();
    frame(8'hD2, '{8'hAA, 8'hBB, 8'hCD, 8'h11, 8'h22, 8'h11, 8'h22});
    chk_mode("R6 bad old", 1);
    frame(8'hD2, '{8'hAA, 8'hBB, 8'hCC, 8'h11, 8'h22, 8'h11, 8'h23});
    chk_mode("R6 bad confirm", 1);
    t_unlock_ok('{8'hAA, 8'hBB, 8'hCC}, "R6 old code kept");
  endtask

  task automatic t_mod_good();
    frame(8'hD2, '{8'hAA, 8'hBB, 8'hCC, 8'h11, 8'h22, 8'h11, 8'h22});
    chk_mode("R5 change code", 2);
    t_lock();
    frame(8'hC5, '{8'hAA, 8'hBB, 8'hCC});
    chk_mode("R5 old code rejected", 1);
    t_unlock_ok('{8'h11, 8'h22}, "R5 new code works");
  endtask

  task automatic t_illegal();
    t_lock();
    frame(8'hD9, '{8'h11, 8'h22, 8'h33, 8'h33});
    chk_mode("R8 illegal length", 1);
    t_unlock_ok('{8'h11, 8'h22}, "R8 code kept");
  endtask

  task automatic t_override();
    t_lock();
    put(8'h83, 1'b1);
    chk(ovr_act == 1, "R9 override set", ovr_act, 1);
    fend();
    chk(ovr_act == 1, "R9 survives own frame", ovr_act, 1);
    put(8'h01, 1'b1);
    put(8'h02, 1'b0);
    chk(ovr_act == 1, "R9 held in next frame", ovr_act, 1);
    chk_mode("R11 override keeps mode", 1);
    fend();
    chk(ovr_act == 0, "R9 cleared after next frame", ovr_act, 0);
  endtask

  task automatic t_clear();
    frame(8'hD0, '{8'h11, 8'h22});
    chk_mode("R7 cleared", 0);
    t_lock();
    frame(8'hC5, '{});
    chk_mode("R7 bare unlock", 2);
  endtask

  task automatic t_max();
    frame(8'hD8, '{1, 2, 3, 4, 5, 6, 7, 8, 1, 2, 3, 4, 5, 6, 7, 8});
    chk_mode("R5 eight bytes", 2);
    t_lock();
    frame(8'hC5, '{1, 2, 3, 4, 5, 6, 7});
    chk_mode("R4 seven of eight", 1);
    t_unlock_ok('{1, 2, 3, 4, 5, 6, 7, 8}, "R3 eight byte unlock");
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ignore();
    t_set_code();
    t_lock();
    t_unlock_bad();
    t_unlock_ok('{8'hAA, 8'hBB, 8'hCC}, "R3 unlock");
    t_lock();
    t_mod_bad();
    t_mod_good();
    t_illegal();
    t_override();
    t_clear();
    t_max();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule